// File: doc/BRIEF.md
# Interrupt-Capable Three-Port GPIO

The block gives software control over 24 pins arranged as three 8-bit ports. A small register bus sets each pin's direction and output level and reads back the pin's state. Every pin input passes through a two-flop synchronizer before anything inside the block uses it.

The low four pins of ports 0 and 1 can raise interrupts when they are inputs. Each of these eight pins has its own enable bit and its own choice between level and edge triggering. A level source holds the interrupt while its pin is low. An edge source latches a falling edge until software clears it.

A fixed map lets on-chip peripherals take over selected pins. PWM outputs can drive the upper nibble of port 0. The upper three pins of port 1 can feed timer trigger inputs. Port 2 pins 1 to 3 can carry a serial bit clock, a frame sync and a converter sync. A control bit turns port 2 pin 6 into an 8 kHz timing input.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every direction, output, alternate-function, interrupt-enable, interrupt-mode and control register reads 0. All pin output enables are low and `irq_o` is low.
- R2: Register map, by `addr_i`: 0..2 direction of ports 0..2 (1 = output); 3..5 output data; 6..8 synchronized input; 9..11 alternate-function select; 12 interrupt enable; 13 interrupt mode; 14 interrupt status; 15 control. A write takes effect at the clock edge that samples `sel_i` and `we_i` high. A read request returns its data on `rdata_o` after that edge, and `rdata_o` holds between reads.
- R3: Pin p of port n is bit 8n+p of `pin_i`, `pin_o` and `pin_oe_o`. A pin with no alternate function active has `pin_oe_o` equal to its direction bit and `pin_o` equal to its output-data bit.
- R4: The input registers return `pin_i` delayed through two flops. A value applied before edge k is returned by a read request sampled at edge k+2 or later.
- R5: Interrupt enable and mode bits [3:0] map to port 0 pins 3..0, and bits [7:4] map to port 1 pins 3..0. A mode bit of 0 selects level. An enabled level source asserts its status bit and `irq_o` while its synchronized pin is 0, and releases them when the pin returns to 1, with no clearing.
- R6: An enabled edge source (mode bit 1) latches a 1-to-0 transition of its synchronized pin. The latch holds after the pin rises again and is cleared by writing 1 to its status bit. A rising edge never sets it, and disabling the source clears it.
- R7: A pin whose direction bit is 1 raises no interrupt, whatever level or edges appear on `pin_i`.
- R8: Alternate-function bits 7..4 of port 0 make those pins outputs (`pin_oe_o` = 1) driven by `pwm_i[3:0]`, with bit 4 taking `pwm_i[0]`.
- R9: Alternate-function bits 7..5 of port 1 force those pins to be inputs. `tmr_trig_o[2:0]` carries their synchronized values, with pin 5 on bit 0. A trigger bit whose select is 0 is 0.
- R10: Alternate-function bits 3..1 of port 2 make those pins outputs driven by `ser_i[2:0]`, with pin 1 taking `ser_i[0]`.
- R11: Control bit 0 forces port 2 pin 6 to be an input, and `tick8k_o` carries its synchronized value. While the bit is 0, `tick8k_o` is 0 and the pin follows its direction bit.
- R12: An alternate-function register stores only the bits that have a peripheral (port 0: 0xF0, port 1: 0xE0, port 2: 0x0E). Other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| pin_i | input | 24 | Pin input levels |
| pin_o | output | 24 | Pin output levels |
| pin_oe_o | output | 24 | Pin output enables |
| pwm_i | input | 4 | PWM outputs routed to port 0 pins 7..4 |
| ser_i | input | 3 | Bit clock, frame sync, converter sync for port 2 pins 1..3 |
| tmr_trig_o | output | 3 | Timer trigger inputs from port 1 pins 5..7 |
| tick8k_o | output | 1 | 8 kHz timing input from port 2 pin 6 |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Results reach the outputs with different delays:
- Register writes change `pin_o` and `pin_oe_o` right after the writing edge.
- A `pin_i` change applied before edge k reaches the synchronized input, the level interrupts and the trigger and tick outputs after edge k+1. An edge latch sets only after edge k+2. Input readback shows the new value for requests sampled at edge k+2.

The bench drives inputs on falling edges and samples on the falling edge after the counted rising edges. Its directed checks pin these latencies exactly: the old value for the first two reads, the edge interrupt still low after two edges and high after three. Its random rounds let the synchronizer settle before comparing.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PORT_W    = 8;
  localparam int NUM_PORTS = 3;
  localparam int NUM_PINS  = PORT_W * NUM_PORTS;
  localparam int ADDR_W    = 4;
  localparam int IRQ_PINS  = 4;
  localparam int IRQ_W     = 2 * IRQ_PINS;
  localparam int SYNC_STG  = 2;

  localparam int N_PWM     = 4;
  localparam int PWM_LSB   = 4;
  localparam int N_TRIG    = 3;
  localparam int TRIG_LSB  = 5;
  localparam int N_SER     = 3;
  localparam int SER_LSB   = 1;
  localparam int TICK_PORT = 2;
  localparam int TICK_PIN  = 6;

  typedef logic [PORT_W-1:0] port_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_DIR   = 4'd0;
  localparam addr_t A_OUT   = 4'd3;
  localparam addr_t A_IN    = 4'd6;
  localparam addr_t A_ALT   = 4'd9;
  localparam addr_t A_IEN   = 4'd12;
  localparam addr_t A_IMODE = 4'd13;
  localparam addr_t A_ISTAT = 4'd14;
  localparam addr_t A_CTRL  = 4'd15;

  // pins whose alternate function drives the pad
  function automatic port_t alt_out_mask(input int p);
    case (p)
      0:       return port_t'(((1 << N_PWM) - 1) << PWM_LSB);
      2:       return port_t'(((1 << N_SER) - 1) << SER_LSB);
      default: return '0;
    endcase
  endfunction

  // pins whose alternate function is an input to a peripheral
  function automatic port_t alt_in_mask(input int p);
    case (p)
      1:       return port_t'(((1 << N_TRIG) - 1) << TRIG_LSB);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic                     valid_q;

  // idle level is high (pulled-up pads)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q   <= '1;
      valid_q <= 1'b0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      valid_q  <= 1'b1;
    end
  end

  assign q_o = stg_q[STAGES-1];

  p_first_stage_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (stg_q[0] == $past(d_i)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_irq_pkg::*;
#(
  parameter port_t ALT_OUT = '0,
  parameter port_t ALT_IN  = '0
) (
  input  port_t out_i,
  input  port_t dir_i,
  input  port_t alt_i,
  input  port_t periph_i,
  input  port_t force_in_i,
  output port_t pin_o,
  output port_t oe_o
);
  port_t eff_out, eff_in;

  always_comb begin
    eff_out = alt_i & ALT_OUT;
    eff_in  = (alt_i & ALT_IN) | force_in_i;
    pin_o   = (out_i & ~eff_out) | (periph_i & eff_out);
    oe_o    = eff_out | (dir_i & ~eff_in);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] in_mask_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] prev_q, edge_q, edge_d, arm, lvl, fall;

  always_comb begin
    arm    = en_i & edge_i & in_mask_i;
    lvl    = en_i & ~edge_i & in_mask_i;
    fall   = prev_q & ~pin_i;
    // set beats clear; disarm drops the latch
    edge_d = ((edge_q & ~clr_i) | fall) & arm;
    pend_o = edge_q | (lvl & ~pin_i);
    irq_o  = |pend_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      edge_q <= '0;
    end else begin
      prev_q <= pin_i;
      edge_q <= edge_d;
    end
  end

  p_edge_needs_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_q & ~$past(edge_q) & ~($past(pin_i, 2) & ~$past(pin_i))) == '0);

  p_edge_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(edge_q & arm & ~clr_i) & arm & ~edge_q) == '0);

  p_level_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o & en_i & ~edge_i & pin_i) == '0);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [PORT_W-1:0]   wdata_i,
  output logic [PORT_W-1:0]   rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  input  logic [N_PWM-1:0]    pwm_i,
  input  logic [N_SER-1:0]    ser_i,
  output logic [N_TRIG-1:0]   tmr_trig_o,
  output logic                tick8k_o,
  output logic                irq_o
);
  port_t [NUM_PORTS-1:0] dir_q, out_q, alt_q, sync_q, periph, force_in;
  logic [IRQ_W-1:0]      ien_q, imode_q, irq_pin, irq_in, clr, pend;
  logic                  ctrl_q;
  logic [NUM_PINS-1:0]   sync_flat;
  port_t                 rd_val, rdata_q;
  logic                  wr_en, rd_en;

  assign wr_en = sel_i & we_i;
  assign rd_en = sel_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      out_q   <= '0;
      alt_q   <= '0;
      ien_q   <= '0;
      imode_q <= '0;
      ctrl_q  <= 1'b0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (addr_i == A_DIR + ADDR_W'(p)) dir_q[p] <= wdata_i;
        if (addr_i == A_OUT + ADDR_W'(p)) out_q[p] <= wdata_i;
        if (addr_i == A_ALT + ADDR_W'(p))
          alt_q[p] <= wdata_i & (alt_out_mask(p) | alt_in_mask(p));
      end
      if (addr_i == A_IEN)   ien_q   <= wdata_i[IRQ_W-1:0];
      if (addr_i == A_IMODE) imode_q <= wdata_i[IRQ_W-1:0];
      if (addr_i == A_CTRL)  ctrl_q  <= wdata_i[0];
    end
  end

  assign clr = (wr_en && addr_i == A_ISTAT) ? wdata_i[IRQ_W-1:0] : '0;

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_flat)
  );

  always_comb begin
    periph   = '0;
    force_in = '0;
    periph[0][PWM_LSB +: N_PWM]      = pwm_i;
    periph[2][SER_LSB +: N_SER]      = ser_i;
    force_in[TICK_PORT][TICK_PIN]    = ctrl_q;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign sync_q[g] = sync_flat[g*PORT_W +: PORT_W];
    gpio_pin_mux #(
      .ALT_OUT (alt_out_mask(g)),
      .ALT_IN  (alt_in_mask(g))
    ) u_mux (
      .out_i      (out_q[g]),
      .dir_i      (dir_q[g]),
      .alt_i      (alt_q[g]),
      .periph_i   (periph[g]),
      .force_in_i (force_in[g]),
      .pin_o      (pin_o[g*PORT_W +: PORT_W]),
      .oe_o       (pin_oe_o[g*PORT_W +: PORT_W])
    );
  end

  assign irq_pin = {sync_q[1][IRQ_PINS-1:0], sync_q[0][IRQ_PINS-1:0]};
  assign irq_in  = ~{dir_q[1][IRQ_PINS-1:0], dir_q[0][IRQ_PINS-1:0]};

  gpio_irq_ctrl #(.N(IRQ_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (irq_pin),
    .en_i      (ien_q),
    .edge_i    (imode_q),
    .in_mask_i (irq_in),
    .clr_i     (clr),
    .pend_o    (pend),
    .irq_o     (irq_o)
  );

  assign tmr_trig_o = sync_q[1][TRIG_LSB +: N_TRIG] & alt_q[1][TRIG_LSB +: N_TRIG];
  assign tick8k_o   = ctrl_q & sync_q[TICK_PORT][TICK_PIN];

  always_comb begin
    rd_val = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr_i == A_DIR + ADDR_W'(p)) rd_val = dir_q[p];
      if (addr_i == A_OUT + ADDR_W'(p)) rd_val = out_q[p];
      if (addr_i == A_IN  + ADDR_W'(p)) rd_val = sync_q[p];
      if (addr_i == A_ALT + ADDR_W'(p)) rd_val = alt_q[p];
    end
    case (addr_i)
      A_IEN:   rd_val = port_t'(ien_q);
      A_IMODE: rd_val = port_t'(imode_q);
      A_ISTAT: rd_val = port_t'(pend);
      A_CTRL:  rd_val = port_t'(ctrl_q);
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  p_rdata_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata_o));

  p_irq_input_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(ien_q & irq_in));

  p_pwm_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_q[0][PWM_LSB] |-> (pin_oe_o[PWM_LSB] && pin_o[PWM_LSB] == pwm_i[0]));

  p_tick_input_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q |-> !pin_oe_o[TICK_PORT*PORT_W + TICK_PIN]);
endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  import gpio_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [23:0] pins = '1;
  logic [23:0] pout, poe;
  logic [3:0]  pwm = '0;
  logic [2:0]  ser = '0;
  logic [2:0]  trig;
  logic        tick, irq;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_irq_port uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .pwm_i(pwm), .ser_i(ser), .tmr_trig_o(trig),
    .tick8k_o(tick), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  function automatic logic [23:0] exp_oe(input logic [2:0][7:0] dir,
      input logic [2:0][7:0] alt, input logic mode);
    logic [7:0] a0 = alt[0] & 8'hF0, a1 = alt[1] & 8'hE0, a2 = alt[2] & 8'h0E;
    logic [7:0] f2 = {1'b0, mode, 6'b0};
    return {a2 | (dir[2] & ~f2), dir[1] & ~a1, a0 | dir[0]};
  endfunction

  function automatic logic [23:0] exp_out(input logic [2:0][7:0] out,
      input logic [2:0][7:0] alt, input logic [3:0] pw, input logic [2:0] sr);
    logic [7:0] a0 = alt[0] & 8'hF0, a2 = alt[2] & 8'h0E;
    return {(out[2] & ~a2) | ({4'b0, sr, 1'b0} & a2), out[1],
            (out[0] & ~a0) | ({pw, 4'b0} & a0)};
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [2:0][7:0] rdir, rout, ralt;
    logic rmode;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick_n(1);

    // R1 reset state
    check("R1 oe", poe, 24'h0);
    check("R1 irq", irq, 0);
    for (int a = 0; a < 16; a++) begin
      if (a >= 6 && a <= 8) continue;
      rd(4'(a), d);
      check("R1 reg", d, 0);
    end

    // R12 alternate-function write masks
    wr(A_ALT + 0, 8'hFF); rd(A_ALT + 0, d); check("R12 alt0", d, 8'hF0);
    wr(A_ALT + 1, 8'hFF); rd(A_ALT + 1, d); check("R12 alt1", d, 8'hE0);
    wr(A_ALT + 2, 8'hFF); rd(A_ALT + 2, d); check("R12 alt2", d, 8'h0E);
    for (int p = 0; p < 3; p++) wr(A_ALT + 4'(p), 8'h00);

    // R3 plain GPIO
    wr(A_DIR + 0, 8'hA5); wr(A_OUT + 0, 8'h3C);
    check("R3 oe", poe[7:0], 8'hA5);
    check("R3 out", pout[7:0], 8'h3C);

    // R4 synchronizer latency
    wr(A_DIR + 0, 8'h00);
    pins = '1; tick_n(3);
    pins[23:16] = 8'h5A;
    rd(A_IN + 2, d); check("R4 lat0", d, 8'hFF);
    rd(A_IN + 2, d); check("R4 lat1", d, 8'hFF);
    rd(A_IN + 2, d); check("R4 lat2", d, 8'h5A);

    // random rounds: R3 R4 R8 R9 R10 R11
    for (int it = 0; it < 40; it++) begin
      for (int p = 0; p < 3; p++) begin
        rdir[p] = 8'($urandom); rout[p] = 8'($urandom); ralt[p] = 8'($urandom);
        wr(A_DIR + 4'(p), rdir[p]); wr(A_OUT + 4'(p), rout[p]); wr(A_ALT + 4'(p), ralt[p]);
      end
      rmode = 1'($urandom);
      wr(A_CTRL, {7'b0, rmode});
      pwm = 4'($urandom); ser = 3'($urandom); pins = 24'($urandom);
      tick_n(3);
      check("R3 R8 R10 R11 rnd oe", poe, exp_oe(rdir, ralt, rmode));
      check("R3 R8 R10 rnd out", pout, exp_out(rout, ralt, pwm, ser));
      check("R9 rnd trig", trig, pins[15:13] & ralt[1][7:5]);
      check("R11 rnd tick", tick, pins[22] & rmode);
      for (int p = 0; p < 3; p++) begin
        rd(A_IN + 4'(p), d);
        check("R4 rnd in", d, pins[p*8 +: 8]);
      end
    end
    for (int p = 0; p < 3; p++) begin
      wr(A_DIR + 4'(p), 0); wr(A_ALT + 4'(p), 0); wr(A_OUT + 4'(p), 0);
    end
    wr(A_CTRL, 0);
    pins = '1; tick_n(3);

    // R5 level interrupts: port0 pin0 and port1 pin2
    wr(A_IMODE, 8'h00); wr(A_IEN, 8'h41);
    check("R5 idle", irq, 0);
    pins[0] = 1'b0; tick_n(2);
    check("R5 level set", irq, 1);
    rd(A_ISTAT, d); check("R5 stat", d, 8'h01);
    pins[0] = 1'b1; tick_n(2);
    check("R5 level release", irq, 0);
    pins[10] = 1'b0; tick_n(2);
    rd(A_ISTAT, d); check("R5 stat p1", d, 8'h40);
    pins[10] = 1'b1; tick_n(2);
    rd(A_ISTAT, d); check("R5 stat clear", d, 8'h00);

    // R6 edge interrupt on port1 pin0
    wr(A_IEN, 8'h10); wr(A_IMODE, 8'h10);
    pins[8] = 1'b0; tick_n(2);
    check("R6 not yet", irq, 0);
    tick_n(1);
    check("R6 latched", irq, 1);
    pins[8] = 1'b1; tick_n(3);
    check("R6 sticky", irq, 1);
    rd(A_ISTAT, d); check("R6 stat", d, 8'h10);
    wr(A_ISTAT, 8'h10);
    check("R6 w1c", irq, 0);
    pins[8] = 1'b0; tick_n(3);
    wr(A_ISTAT, 8'h10);
    pins[8] = 1'b1; tick_n(4);
    check("R6 rise ignored", irq, 0);
    rd(A_ISTAT, d); check("R6 rise stat", d, 8'h00);

    // R7 outputs do not interrupt
    wr(A_DIR + 0, 8'h01); wr(A_IEN, 8'h01); wr(A_IMODE, 8'h00);
    pins[0] = 1'b0; tick_n(3);
    check("R7 level", irq, 0);
    wr(A_IMODE, 8'h01);
    pins[0] = 1'b1; tick_n(3); pins[0] = 1'b0; tick_n(4);
    check("R7 edge", irq, 0);
    rd(A_ISTAT, d); check("R7 stat", d, 8'h00);
    wr(A_IEN, 0); wr(A_DIR + 0, 0); pins = '1;

    // R9 timer triggers
    wr(A_DIR + 1, 8'hFF); wr(A_ALT + 1, 8'hE0);
    check("R9 oe", poe[15:8], 8'h1F);
    pins[15:13] = 3'b101; tick_n(2);
    check("R9 trig", trig, 3'b101);
    wr(A_ALT + 1, 8'h00);
    check("R9 trig off", trig, 3'b000);

    // R11 timing input
    wr(A_DIR + 2, 8'hFF); wr(A_CTRL, 8'h01);
    check("R11 forced in", poe[22], 0);
    pins[22] = 1'b0; tick_n(2); check("R11 tick low", tick, 0);
    pins[22] = 1'b1; tick_n(2); check("R11 tick high", tick, 1);
    wr(A_CTRL, 8'h00);
    check("R11 tick off", tick, 0);
    check("R11 pin back", poe[22], 1);

    report();
    $finish;
  end
endmodule